// File: doc/BRIEF.md
# Per-Thread Interrupt Presentation Context

This block is the interrupt presentation state of a single processor thread. An upstream router raises one notification at a time, carrying a priority byte and a source kind. The block holds the most urgent pending notification and compares it against the thread's current priority threshold. It drives an interrupt line while the pending entry is strictly more urgent than that threshold. Numerically lower priorities are more urgent.

Software reaches the block through a byte-addressed window with three rings: guest OS at 0x10, hypervisor pool at 0x20 and hypervisor at 0x30. Each ring has its own threshold byte. Only the hypervisor ring's threshold gates the line. A 16-bit read at 0x800 acknowledges the interrupt: it returns the source kind and the priority packed into one word, moves the threshold to that priority, and drops the line. The pool ring also carries a 32-bit context word whose top bit marks it valid. A 64-bit read at 0x828 pulls that context out and invalidates it.

Reads return data combinationally in the cycle the access is presented. Side effects take place at the clock edge that ends that cycle.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset the line is low, all three ring thresholds read 0x00, the pool word reads 0, and an acknowledge returns 0x00FF.
- R2: The line is high exactly when an entry is pending and its priority is numerically below the hypervisor threshold. The threshold is the byte at 0x31. A byte read of 0x30 returns the source kind in bits 7:6 while the line is high and 0 otherwise. A byte read of 0x37 returns the pending priority, or 0xFF when nothing is pending.
- R3: A 16-bit read of 0x800 while the line is high returns the source kind in bits 15:14, zeros in bits 13:8 and the pending priority in bits 7:0. The kind codes are 1 = pool, 2 = physical, 3 = level.
- R4: After a taken acknowledge, the hypervisor threshold equals the acknowledged priority. The pending entry is cleared: the line is low, 0x30 reads 0 and 0x37 reads 0xFF.
- R5: A 16-bit read of 0x800 while the line is low returns 0x00FF and changes no state.
- R6: A notification with priority 0xFF or kind 0 is ignored.
- R7: A notification replaces the pending entry only if nothing is pending or its priority is numerically lower than the pending one.
- R8: The 32-bit pool word at 0x28 is writable and readable, and bit 31 is its valid flag. A 64-bit read of 0x828 returns the word in bits 31:0 and clears bit 31.
- R9: The OS threshold (0x11) and the pool threshold (0x21) are written and read with byte accesses independently of the hypervisor threshold, and they do not gate the line.
- R10: An access to 0x800 or 0x828 with any other size has no side effect. A byte read of 0x800 returns 0.
- R11: When a notification and a taken acknowledge occur in the same cycle, the acknowledge completes first. The notification is then treated as arriving with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_vld | input | 1 | Notification strobe |
| ntf_prio | input | 8 | Notification priority |
| ntf_kind | input | 2 | Notification source kind (1 pool, 2 physical, 3 level) |
| acc_vld | input | 1 | Window access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Window byte address |
| acc_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| acc_wdata | input | 64 | Write data, right-aligned |
| acc_rdata | output | 64 | Read data, right-aligned, combinational |
| irq_out | output | 1 | Interrupt line to the thread |

## Verification
The notification path is driven with a sequence of priorities 9, 3 and 6, which shows that only a more urgent entry displaces the held one. Notifications of priority 0xFF and of kind 0 show that the filter discards them. The threshold is swept from masking (0x00) to open (0xFF) with a priority-5 entry held, which separates the line logic from the pending storage. Acknowledges are issued with the line high, with the line low, with the wrong size, and in the same cycle as a new notification; these cases tell the packing, the write-back of the priority and the ordering apart.

// File: rtl/thread_irq_ctx.sv
`timescale 1ns/1ps
module thread_irq_ctx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ntf_vld,
  input  logic [7:0]  ntf_prio,
  input  logic [1:0]  ntf_kind,
  input  logic        acc_vld,
  input  logic        acc_wr,
  input  logic [11:0] acc_addr,
  input  logic [1:0]  acc_size,
  input  logic [63:0] acc_wdata,
  output logic [63:0] acc_rdata,
  output logic        irq_out
);
  localparam logic [11:0] ACK_ADDR  = 12'h800;
  localparam logic [11:0] PULL_ADDR = 12'h828;
  localparam logic [11:0] POOL_ADDR = 12'h028;
  localparam logic [7:0]  IDLE_PRIO = 8'hFF;

  logic [7:0]  thr_os, thr_pool, thr_hv, pend_prio;
  logic [1:0]  pend_kind;
  logic [31:0] pool_word;

  wire pending = pend_kind != 2'd0;
  assign irq_out = pending && (pend_prio < thr_hv);

  wire rd = acc_vld && !acc_wr;
  wire wr = acc_vld && acc_wr;
  wire ack_hit  = rd && acc_addr == ACK_ADDR && acc_size == 2'd1;
  wire ack_take = ack_hit && irq_out;
  wire pull_hit = rd && acc_addr == PULL_ADDR && acc_size == 2'd3;
  wire pool_wr  = wr && acc_addr == POOL_ADDR && acc_size == 2'd2;

  wire [1:0] ring   = acc_addr[5:4];
  wire [2:0] offs   = acc_addr[2:0];
  wire in_ring      = acc_addr[11:6] == 6'd0 && ring != 2'd0 && !acc_addr[3];
  wire thr_wr       = wr && in_ring && acc_size == 2'd0 && offs == 3'd1;

  wire ntf_ok   = ntf_vld && ntf_kind != 2'd0 && ntf_prio != IDLE_PRIO;
  wire held     = pending && !ack_take;
  wire ntf_take = ntf_ok && (!held || ntf_prio < pend_prio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_os    <= 8'h00;
      thr_pool  <= 8'h00;
      thr_hv    <= 8'h00;
      pend_prio <= IDLE_PRIO;
      pend_kind <= 2'd0;
      pool_word <= 32'd0;
    end else begin
      if (ntf_take) begin
        pend_prio <= ntf_prio;
        pend_kind <= ntf_kind;
      end else if (ack_take) begin
        pend_prio <= IDLE_PRIO;
        pend_kind <= 2'd0;
      end
      if (ack_take) thr_hv <= pend_prio;
      else if (thr_wr && ring == 2'd3) thr_hv <= acc_wdata[7:0];
      if (thr_wr && ring == 2'd1) thr_os   <= acc_wdata[7:0];
      if (thr_wr && ring == 2'd2) thr_pool <= acc_wdata[7:0];
      if (pool_wr) pool_word <= acc_wdata[31:0];
      else if (pull_hit) pool_word[31] <= 1'b0;
    end
  end

  logic [7:0] ring_byte;
  always_comb begin
    ring_byte = 8'h00;
    case (offs)
      3'd0: if (ring == 2'd3 && irq_out) ring_byte = {pend_kind, 6'd0};
      3'd1: ring_byte = (ring == 2'd1) ? thr_os : (ring == 2'd2) ? thr_pool : thr_hv;
      3'd7: if (ring == 2'd3) ring_byte = pend_prio;
      default: ring_byte = 8'h00;
    endcase
  end

  always_comb begin
    acc_rdata = 64'd0;
    if (rd) begin
      if (ack_hit)
        acc_rdata[15:0] = irq_out ? {pend_kind, 6'd0, pend_prio} : 16'h00FF;
      else if (pull_hit || (acc_addr == POOL_ADDR && acc_size == 2'd2))
        acc_rdata[31:0] = pool_word;
      else if (in_ring && acc_size == 2'd0)
        acc_rdata[7:0] = ring_byte;
    end
  end

  // R4
  ack_drops_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !ntf_vld) |=> !irq_out);
  // R4
  ack_moves_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> thr_hv == $past(pend_prio));
  // R5
  idle_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !irq_out && !ntf_vld) |=> $stable(thr_hv) && $stable(pend_kind));
  // R8
  pull_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_hit |=> !pool_word[31]);
  // R6
  ignore_idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_vld && ntf_prio == IDLE_PRIO && !acc_vld) |=> $stable(pend_prio) && $stable(pend_kind));
  // R7
  keep_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ntf_vld && ntf_prio >= pend_prio && !acc_vld) |=> $stable(pend_prio));
endmodule

// File: tb/test_thread_irq_ctx.sv
`timescale 1ns/1ps
module test_thread_irq_ctx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ntf_vld = 1'b0; logic [7:0] ntf_prio = 8'h0; logic [1:0] ntf_kind = 2'd0;
  logic acc_vld = 1'b0, acc_wr = 1'b0; logic [11:0] acc_addr = 12'h0;
  logic [1:0] acc_size = 2'd0; logic [63:0] acc_wdata = 64'd0;
  logic [63:0] acc_rdata; logic irq_out;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  thread_irq_ctx i_thread_irq_ctx (.clk, .rst_n, .ntf_vld, .ntf_prio, .ntf_kind,
    .acc_vld, .acc_wr, .acc_addr, .acc_size, .acc_wdata, .acc_rdata, .irq_out);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] s, output logic [63:0] d);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_size = s;
    #1 d = acc_rdata;
    @(posedge clk); #1 acc_vld = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [63:0] v);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_size = s; acc_wdata = v;
    @(posedge clk); #1 acc_vld = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic notify(input logic [7:0] p, input logic [1:0] k);
    @(negedge clk);
    ntf_vld = 1'b1; ntf_prio = p; ntf_kind = k;
    @(posedge clk); #1 ntf_vld = 1'b0;
  endtask

  task automatic line(input string req, input logic exp);
    @(negedge clk); check(req, {63'd0, irq_out}, {63'd0, exp});
  endtask

  task automatic t_reset;
    logic [63:0] d;
    line("R1 line", 1'b0);
    rd(12'h031, 2'd0, d); check("R1 hv thr", d, 64'h00);
    rd(12'h011, 2'd0, d); check("R1 os thr", d, 64'h00);
    rd(12'h028, 2'd2, d); check("R1 pool", d, 64'h0);
    rd(12'h800, 2'd1, d); check("R1 ack", d, 64'h00FF);
  endtask

  task automatic t_mask;
    logic [63:0] d;
    notify(8'd5, 2'd2);
    line("R2 masked", 1'b0);
    rd(12'h030, 2'd0, d); check("R2 kind masked", d, 64'h00);
    wr(12'h031, 2'd0, 64'hFF);
    line("R2 open", 1'b1);
    rd(12'h030, 2'd0, d); check("R2 kind byte", d, 64'h80);
    rd(12'h037, 2'd0, d); check("R2 pend prio", d, 64'h05);
  endtask

  task automatic t_ack;
    logic [63:0] d;
    rd(12'h800, 2'd1, d); check("R3 ack word", d, 64'h8005);
    line("R4 line dropped", 1'b0);
    rd(12'h031, 2'd0, d); check("R4 thr moved", d, 64'h05);
    rd(12'h037, 2'd0, d); check("R4 pend cleared", d, 64'hFF);
    rd(12'h030, 2'd0, d); check("R4 kind cleared", d, 64'h00);
  endtask

  task automatic t_idle_ack;
    logic [63:0] d;
    rd(12'h800, 2'd1, d); check("R5 idle ack", d, 64'h00FF);
    rd(12'h031, 2'd0, d); check("R5 thr kept", d, 64'h05);
  endtask

  task automatic t_ignore;
    logic [63:0] d;
    wr(12'h031, 2'd0, 64'hFF);
    notify(8'hFF, 2'd2);
    notify(8'd2, 2'd0);
    line("R6 ignored", 1'b0);
    rd(12'h037, 2'd0, d); check("R6 nothing pending", d, 64'hFF);
  endtask

  task automatic t_replace;
    logic [63:0] d;
    notify(8'd9, 2'd1);
    notify(8'd3, 2'd3);
    notify(8'd6, 2'd2);
    rd(12'h037, 2'd0, d); check("R7 most urgent kept", d, 64'h03);
    rd(12'h800, 2'd1, d); check("R7 R3 level ack", d, 64'hC003);
  endtask

  task automatic t_pool;
    logic [63:0] d;
    wr(12'h028, 2'd2, 64'h8000_0042);
    rd(12'h028, 2'd2, d); check("R8 pool rw", d, 64'h8000_0042);
    rd(12'h828, 2'd3, d); check("R8 pull data", d, 64'h8000_0042);
    rd(12'h028, 2'd2, d); check("R8 valid cleared", d, 64'h0000_0042);
  endtask

  task automatic t_rings;
    logic [63:0] d;
    wr(12'h031, 2'd0, 64'hFF);
    wr(12'h011, 2'd0, 64'h40);
    wr(12'h021, 2'd0, 64'h50);
    rd(12'h011, 2'd0, d); check("R9 os thr", d, 64'h40);
    rd(12'h021, 2'd0, d); check("R9 pool thr", d, 64'h50);
    rd(12'h031, 2'd0, d); check("R9 hv thr kept", d, 64'hFF);
    notify(8'h60, 2'd2);
    line("R9 only hv gates", 1'b1);
  endtask

  task automatic t_size;
    logic [63:0] d;
    rd(12'h800, 2'd0, d); check("R10 byte ack data", d, 64'h0);
    line("R10 line kept", 1'b1);
    wr(12'h028, 2'd2, 64'h8000_0001);
    rd(12'h828, 2'd2, d);
    rd(12'h028, 2'd2, d); check("R10 pull wrong size", d, 64'h8000_0001);
    rd(12'h800, 2'd1, d); check("R10 clean ack", d, 64'h8060);
  endtask

  task automatic t_collide;
    logic [63:0] d;
    wr(12'h031, 2'd0, 64'hFF);
    notify(8'd4, 2'd2);
    @(negedge clk);
    ntf_vld = 1'b1; ntf_prio = 8'd7; ntf_kind = 2'd1;
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = 12'h800; acc_size = 2'd1;
    #1 check("R11 ack word", acc_rdata, 64'h8004);
    @(posedge clk); #1 ntf_vld = 1'b0; acc_vld = 1'b0;
    rd(12'h037, 2'd0, d); check("R11 new pending", d, 64'h07);
    line("R11 masked by new thr", 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset(); t_mask(); t_ack(); t_idle_ack(); t_ignore();
    t_replace(); t_pool(); t_rings(); t_size(); t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule